// File: doc/BRIEF.md
# Exhaustive Single Stuck-At Fault Sweeper

This block grades one single stuck-at fault on a small fixed four-input combinational network, Z = x1·(x2 + x3) + (not x1)·x4. After a start pulse it steps through all sixteen input combinations, one per clock. On each step it evaluates two copies of the network on the same inputs. The first copy is fault free. In the second copy one chosen line is forced to a constant. Whenever the two outputs disagree, the vector is streamed out with a valid strobe.

When the sweep ends, a done flag rises. The number of detecting vectors is held beside it. A flag marks the fault as undetectable when no vector exposed it. The fanout of x1 is modelled as three separate lines, the stem and its two branches, so each can be faulted on its own. A fault select that names no existing line is refused with an error flag, and no sweep starts.

Top module: `fsim_sweep`

## Requirements
- R1: After reset the block is idle and done, undetectable, sel_err, hit_valid and hit_count are all 0.
- R2: A sweep visits the vectors in ascending order 0 to 15, one per clock. Input bit 3 is x1, bit 2 is x2, bit 1 is x3 and bit 0 is x4. The detecting vectors come out on hit_vec in ascending order.
- R3: hit_valid is 1 for a vector exactly when the fault-free output differs from the output of the faulted network for that vector.
- R4: With x4 stuck at 0 (site 5, value 0), exactly vectors 1, 3, 5 and 7 are reported, and hit_count ends at 4.
- R5: Fault sites are numbered as follows: 0 x1 stem, 1 x1 branch into the x1·(x2+x3) product, 2 x1 branch into the inverter, 3 x2, 4 x3, 5 x4, 6 OR output, 7 inverter output, 8 upper AND output, 9 lower AND output, 10 Z. Each site is faulted independently of the others.
- R6: fault_val selects stuck-at-0 (0) or stuck-at-1 (1), and both polarities are supported on every site.
- R7: done rises 16 clocks after the clock that accepts start, together with the result for vector 15. It stays high with hit_count holding the number of detecting vectors until the next start.
- R8: undetectable is 1 while done is high exactly when hit_count is 0.
- R9: A start with fault_site above 10 sets sel_err, clears done, produces no hit_valid and starts no sweep. A later valid start clears sel_err.
- R10: A start pulse, or a change of the fault select, while a sweep is running has no effect on that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sweep when the block is idle |
| fault_site | input | 4 | Index of the line to fault |
| fault_val | input | 1 | Stuck value of the line |
| hit_valid | output | 1 | Strobe marking a detecting vector |
| hit_vec | output | 4 | The detecting vector |
| done | output | 1 | Sweep finished; held until the next start |
| undetectable | output | 1 | No vector detected the fault |
| hit_count | output | 5 | Number of detecting vectors |
| sel_err | output | 1 | The last start named a site that does not exist |

## Verification
The bench builds the block with its default parameters: four input bits and eleven sites. At these values every one of the 22 possible faults can be swept in full, so the whole fault list is graded against a vector-by-vector reference model. The same defaults keep the last valid index, 10, next to the invalid indices 11 and 15. This allows the rejection boundary to be probed from both sides. The sixteen-vector window also leaves room to pulse start again partway through a sweep.

// File: rtl/fsim_pkg.sv
package fsim_pkg;
    localparam int VEC_W     = 4;
    localparam int NUM_VEC   = 1 << VEC_W;
    localparam int SITE_W    = 4;
    localparam int NUM_SITES = 11;
    localparam int CNT_W     = VEC_W + 1;
    localparam int COPIES    = 2;

    localparam logic [SITE_W-1:0] S_X1_STEM = 4'd0;
    localparam logic [SITE_W-1:0] S_X1_AND  = 4'd1;
    localparam logic [SITE_W-1:0] S_X1_INV  = 4'd2;
    localparam logic [SITE_W-1:0] S_X2      = 4'd3;
    localparam logic [SITE_W-1:0] S_X3      = 4'd4;
    localparam logic [SITE_W-1:0] S_X4      = 4'd5;
    localparam logic [SITE_W-1:0] S_OR      = 4'd6;
    localparam logic [SITE_W-1:0] S_INV     = 4'd7;
    localparam logic [SITE_W-1:0] S_AND_HI  = 4'd8;
    localparam logic [SITE_W-1:0] S_AND_LO  = 4'd9;
    localparam logic [SITE_W-1:0] S_Z       = 4'd10;
    localparam logic [SITE_W-1:0] LAST_SITE = SITE_W'(NUM_SITES - 1);

    typedef enum logic {ST_IDLE, ST_RUN} state_e;

    typedef struct packed {
        state_e             st;
        logic [VEC_W-1:0]   vec;
        logic [SITE_W-1:0]  site;
        logic               sval;
        logic               hit_v;
        logic [VEC_W-1:0]   hit_vec;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic               undet;
        logic               err;
    } ctl_s;
endpackage

// File: rtl/fsim_netlist.sv
module fsim_netlist
    import fsim_pkg::*;
(
    input  logic [VEC_W-1:0]  vec,
    input  logic              inj_en,
    input  logic [SITE_W-1:0] site,
    input  logic              sval,
    output logic              z
);
    function automatic logic tap(input logic v, input logic en,
                                 input logic [SITE_W-1:0] sel,
                                 input logic [SITE_W-1:0] id,
                                 input logic stuck);
        return (en && sel == id) ? stuck : v;
    endfunction

    logic x1s, x1a, x1i, x2, x3, x4, or_o, inv_o, and_hi, and_lo;

    always_comb begin
        x1s    = tap(vec[3], inj_en, site, S_X1_STEM, sval);
        x1a    = tap(x1s, inj_en, site, S_X1_AND, sval);
        x1i    = tap(x1s, inj_en, site, S_X1_INV, sval);
        x2     = tap(vec[2], inj_en, site, S_X2, sval);
        x3     = tap(vec[1], inj_en, site, S_X3, sval);
        x4     = tap(vec[0], inj_en, site, S_X4, sval);
        or_o   = tap(x2 | x3, inj_en, site, S_OR, sval);
        inv_o  = tap(~x1i, inj_en, site, S_INV, sval);
        and_hi = tap(or_o & x1a, inj_en, site, S_AND_HI, sval);
        and_lo = tap(inv_o & x4, inj_en, site, S_AND_LO, sval);
        z      = tap(and_hi | and_lo, inj_en, site, S_Z, sval);
    end
endmodule

// File: rtl/fsim_ctrl.sv
module fsim_ctrl
    import fsim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SITE_W-1:0] fault_site,
    input  logic              fault_val,
    input  logic              detect,
    output logic [VEC_W-1:0]  cur_vec,
    output logic [SITE_W-1:0] cur_site,
    output logic              cur_sval,
    output logic              hit_valid,
    output logic [VEC_W-1:0]  hit_vec,
    output logic              done,
    output logic              undetectable,
    output logic [CNT_W-1:0]  hit_count,
    output logic              sel_err
);
    ctl_s cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.hit_v = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.done  = 1'b0;
                    nxt_d.undet = 1'b0;
                    if (fault_site > LAST_SITE) begin
                        nxt_d.err = 1'b1;
                    end else begin
                        nxt_d.err  = 1'b0;
                        nxt_d.st   = ST_RUN;
                        nxt_d.vec  = '0;
                        nxt_d.site = fault_site;
                        nxt_d.sval = fault_val;
                        nxt_d.cnt  = '0;
                    end
                end
            end
            ST_RUN: begin
                nxt_d.hit_v = detect;
                if (detect) begin
                    nxt_d.hit_vec = cur_q.vec;
                    nxt_d.cnt     = cur_q.cnt + CNT_W'(1);
                end
                if (&cur_q.vec) begin
                    nxt_d.st    = ST_IDLE;
                    nxt_d.done  = 1'b1;
                    nxt_d.undet = (nxt_d.cnt == '0);
                end else begin
                    nxt_d.vec = cur_q.vec + VEC_W'(1);
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cur_vec      = cur_q.vec;
    assign cur_site     = cur_q.site;
    assign cur_sval     = cur_q.sval;
    assign hit_valid    = cur_q.hit_v;
    assign hit_vec      = cur_q.hit_vec;
    assign done         = cur_q.done;
    assign undetectable = cur_q.undet;
    assign hit_count    = cur_q.cnt;
    assign sel_err      = cur_q.err;

    // R2
    vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_RUN && $past(cur_q.st == ST_RUN)) |-> cur_q.vec == $past(cur_q.vec) + VEC_W'(1));
    // R7
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.done) |-> ($past(cur_q.st == ST_RUN) && $past(&cur_q.vec)));
    // R8
    undet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.undet |-> (cur_q.done && cur_q.cnt == '0));
    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.err) |-> (cur_q.st == ST_IDLE && !cur_q.done));
    // R10
    site_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_RUN && $past(cur_q.st == ST_RUN)) |-> $stable(cur_q.site) && $stable(cur_q.sval));
    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= CNT_W'(NUM_VEC));
endmodule

// File: rtl/fsim_sweep.sv
module fsim_sweep
    import fsim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        fault_site,
    input  logic              fault_val,
    output logic              hit_valid,
    output logic [3:0]        hit_vec,
    output logic              done,
    output logic              undetectable,
    output logic [4:0]        hit_count,
    output logic              sel_err
);
    logic [VEC_W-1:0]  cur_vec;
    logic [SITE_W-1:0] cur_site;
    logic              cur_sval;
    logic [COPIES-1:0] z_pair;
    logic              detect;

    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        fsim_netlist u_net (
            .vec    (cur_vec),
            .inj_en (g == 1),
            .site   (cur_site),
            .sval   (cur_sval),
            .z      (z_pair[g])
        );
    end

    assign detect = z_pair[0] ^ z_pair[1];

    fsim_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .fault_site   (fault_site),
        .fault_val    (fault_val),
        .detect       (detect),
        .cur_vec      (cur_vec),
        .cur_site     (cur_site),
        .cur_sval     (cur_sval),
        .hit_valid    (hit_valid),
        .hit_vec      (hit_vec),
        .done         (done),
        .undetectable (undetectable),
        .hit_count    (hit_count),
        .sel_err      (sel_err)
    );
endmodule

// File: tb/fsim_sweep_bench.sv
module fsim_sweep_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] fault_site = '0;
    logic fault_val = 1'b0;
    logic hit_valid, done, undetectable, sel_err;
    logic [3:0] hit_vec;
    logic [4:0] hit_count;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [3:0] exp_q[$];

    always #4 clk = ~clk;

    fsim_sweep u_fsim_sweep (
        .clk(clk), .rst_n(rst_n), .start(start), .fault_site(fault_site),
        .fault_val(fault_val), .hit_valid(hit_valid), .hit_vec(hit_vec),
        .done(done), .undetectable(undetectable), .hit_count(hit_count),
        .sel_err(sel_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: line values of the network, index = site number (R5)
    function automatic logic ref_z(input logic [3:0] v, input int s, input logic sv, input logic inj);
        logic ln[0:10];
        ln[0]  = v[3];                     if (inj && s == 0)  ln[0]  = sv;
        ln[1]  = ln[0];                    if (inj && s == 1)  ln[1]  = sv;
        ln[2]  = ln[0];                    if (inj && s == 2)  ln[2]  = sv;
        ln[3]  = v[2];                     if (inj && s == 3)  ln[3]  = sv;
        ln[4]  = v[1];                     if (inj && s == 4)  ln[4]  = sv;
        ln[5]  = v[0];                     if (inj && s == 5)  ln[5]  = sv;
        ln[6]  = ln[3] | ln[4];            if (inj && s == 6)  ln[6]  = sv;
        ln[7]  = !ln[2];                   if (inj && s == 7)  ln[7]  = sv;
        ln[8]  = ln[6] & ln[1];            if (inj && s == 8)  ln[8]  = sv;
        ln[9]  = ln[7] & ln[5];            if (inj && s == 9)  ln[9]  = sv;
        ln[10] = ln[8] | ln[9];            if (inj && s == 10) ln[10] = sv;
        return ln[10];
    endfunction

    // Monitor: pops expected detecting vectors (R2, R3)
    always @(posedge clk) begin
        #2;
        if (rst_n && hit_valid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected hit", int'(hit_vec), -1);
            end else begin
                check("R2/R3 hit vector", int'(hit_vec), int'(exp_q.pop_front()));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_fault(input int s, input logic sv, input logic mid_start);
        int exp_cnt = 0;
        for (int v = 0; v < 16; v++) begin
            if (ref_z(4'(v), s, sv, 1'b0) != ref_z(4'(v), s, sv, 1'b1)) begin
                exp_q.push_back(4'(v));
                exp_cnt++;
            end
        end
        @(negedge clk);
        fault_site = 4'(s);
        fault_val  = sv;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (mid_start && k == 3) begin   // R10
                start = 1'b1;
                fault_site = 4'd10;
                fault_val = ~sv;
            end else begin
                start = 1'b0;
            end
        end
        check("R7 done not early", int'(done), 0);
        @(negedge clk);
        check("R7 done after 16", int'(done), 1);
        check("R7 hit_count", int'(hit_count), exp_cnt);
        check("R8 undetectable", int'(undetectable), int'(exp_cnt == 0));
        check("R3 all hits seen", exp_q.size(), 0);
        exp_q.delete();
        repeat (2) @(negedge clk);
        check("R7 done held", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 done", int'(done), 0);
        check("R1 undetectable", int'(undetectable), 0);
        check("R1 sel_err", int'(sel_err), 0);
        check("R1 hit_valid", int'(hit_valid), 0);
        check("R1 hit_count", int'(hit_count), 0);
        rst_n = 1'b1;

        // R4: x4 stuck at 0 -> vectors 1,3,5,7
        begin
            int n = 0;
            for (int v = 0; v < 16; v++)
                if (ref_z(4'(v), 5, 1'b0, 1'b0) != ref_z(4'(v), 5, 1'b0, 1'b1)) n++;
            check("R4 model count", n, 4);
        end
        run_fault(5, 1'b0, 1'b0);
        check("R4 hit_count", int'(hit_count), 4);
        check("R4 last hit", int'(hit_vec), 7);

        // R5, R6: every site, both polarities
        for (int s = 0; s < 11; s++) begin
            run_fault(s, 1'b0, 1'b0);
            run_fault(s, 1'b1, 1'b0);
        end

        // R10: start pulse and select change mid-sweep ignored
        run_fault(1, 1'b0, 1'b1);
        run_fault(7, 1'b1, 1'b1);

        // R9: out-of-range sites
        for (int b = 11; b < 16; b += 4) begin
            @(negedge clk);
            fault_site = 4'(b);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R9 sel_err set", int'(sel_err), 1);
            check("R9 done cleared", int'(done), 0);
            repeat (20) @(negedge clk);
            check("R9 no sweep done", int'(done), 0);
        end
        run_fault(10, 1'b1, 1'b0);
        check("R9 sel_err cleared", int'(sel_err), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule